// File: doc/BRIEF.md
# Two-wire serial EEPROM transaction sequencer

This block turns a single user request (read, write or erase of a run of bytes starting at a given word address) into the series of byte-level commands that a two-wire serial EEPROM expects. It sits directly on top of a byte-level bus engine. The engine produces START and STOP conditions, shifts single bytes out and in, and returns one response per command. The sequencer issues one engine command at a time, waits for its response, checks the status, and decides what to issue next. Read bytes stream back on a response port. A one-cycle done pulse and a two-bit error code close every transfer.

A parameter selects between two device styles. Small parts take a one-byte word address, and the three address bits above it travel inside the device select byte. Large parts take a two-byte word address and keep the block bits of the select byte at zero. A device that is still busy with an internal write cycle refuses its select byte. The sequencer then repeats START plus the write-mode select until the device answers, up to a configurable retry limit.

Top module: `eeprom_seq`

## Requirements
- R1: The select byte is 0xA0 OR (block << 1) OR rw, where rw is 0 for write mode and 1 for read mode. For small parts (WIDE_ADDR=0) the block is address bits [10:8], so address 0x5A3 gives 0xAA for write mode and 0xAB for read mode.
- R2: For small parts exactly one word-address byte follows the write-mode select, and it carries address bits [7:0].
- R3: For large parts (WIDE_ADDR=1) the block bits are zero, so the selects are 0xA0 and 0xA1. Two word-address bytes follow the select: bits [15:8] first, then bits [7:0].
- R4: A write (req_op=1) sends START, the write-mode select, the address byte(s), then req_len+1 data bytes. Each data byte is taken from wdata in the cycle where wdata_req is high, which is exactly once per byte.
- R5: If the write-mode select gets NACK (eng_status=1), the sequencer issues a new START and resends the select without a STOP in between.
- R6: Up to RETRY_MAX select NACKs in one transfer are tolerated. The next NACK after that ends the transfer with error code 3 (timeout), and no data is written.
- R7: A failed START, or a response that is neither ACK (0) nor NACK (1) to a select, ends the transfer with error code 2 (bus fault).
- R8: A read (req_op=0) sends START, the write-mode select, the address byte(s), a repeated START, the read-mode select, and then reads req_len+1 bytes. The bytes come out on rd_data with rd_valid, in address order.
- R9: During a read the sequencer answers every received byte with ACK (eng_mack=1) except the last one, which gets NACK (eng_mack=0).
- R10: A NACK on a data byte during a write, on an address byte, or on the read-mode select ends the transfer with error code 1.
- R11: An erase (req_op=2) writes 0xFF to every byte of the range and never raises wdata_req.
- R12: Every transfer, whether it succeeds or aborts, ends with exactly one STOP, followed by done high for one cycle. err_code is cleared when a request is accepted and then holds its final value until the next request is accepted.
- R13: The sequencer never issues an engine command while a previous one is still waiting for eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request accepted when both high |
| req_op | input | 2 | 0 read, 1 write, 2 erase |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Byte count minus one |
| wdata_req | output | 1 | Write byte consumed this cycle |
| wdata | input | 8 | Write byte for the current position |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 2 | 0 ok, 1 NACK, 2 bus fault, 3 timeout |
| eng_cmd_valid | output | 1 | Engine command strobe |
| eng_cmd | output | 2 | 0 START, 1 send byte, 2 receive byte, 3 STOP |
| eng_wdata | output | 8 | Byte to send |
| eng_mack | output | 1 | Master ACK for a receive command |
| eng_done | input | 1 | Engine response strobe |
| eng_status | input | 2 | 0 ACK/ok, 1 NACK, 2 or 3 fault |
| eng_rdata | input | 8 | Received byte |

## Verification
A behavioural device model sits behind a bench-side engine. The model refuses selects for a programmed number of attempts after each write, and it can inject data NACKs, read-select NACKs, START failures and select faults. Writes followed by reads of differing lengths check address formation and byte ordering. A one-byte read separates the last-byte NACK from the ACK given to earlier bytes. Busy counts of zero, three, RETRY_MAX and RETRY_MAX+1 tell plain polling apart from the retry limit boundary. Each injected fault maps to a distinct error code. An erase, followed by a read that overlaps written data, shows that the fill value replaced the stored bytes. A second instance built for large parts checks the two-byte, most-significant-first address and the zero block bits.

// File: rtl/eeprom_seq_pkg.sv
// Shared constants and types for the serial EEPROM sequencer.
package eeprom_seq_pkg;
    localparam logic [7:0] DEV_CODE   = 8'hA0;
    localparam logic [7:0] ERASE_FILL = 8'hFF;
    localparam logic [1:0] BS_ACK     = 2'd0;
    localparam logic [1:0] BS_NACK    = 2'd1;

    typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_ERASE = 2'd2, OP_SPARE = 2'd3} op_e;
    typedef enum logic [1:0] {BC_START = 2'd0, BC_SEND = 2'd1, BC_RECV = 2'd2, BC_STOP = 2'd3} bus_cmd_e;
    typedef enum logic [1:0] {EC_NONE = 2'd0, EC_NACK = 2'd1, EC_BUS = 2'd2, EC_TIMEOUT = 2'd3} err_e;
    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_SELW, ST_ADDR, ST_WDATA,
        ST_RSTART, ST_SELR, ST_RDATA, ST_STOP, ST_DONE
    } state_e;
endpackage

// File: rtl/eeprom_addr_fmt.sv
// Address formatter: builds the write/read select bytes and the word
// address byte(s) from a start address. Assumes ADDR_W >= 16.
// WIDE=0: block bits [10:8] go into select bits [3:1], one address byte.
// WIDE=1: block bits zero, two address bytes (high byte first).
module eeprom_addr_fmt
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter bit WIDE   = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        sel_wr,
    output logic [7:0]        sel_rd,
    output logic [7:0]        addr_hi,
    output logic [7:0]        addr_lo
);
    logic [2:0] blk;

    generate
        if (WIDE) begin : g_wide
            logic unused_top;
            // Two-byte address: block bits stay zero
            always_comb begin
                blk     = 3'd0;
                addr_hi = addr[15:8];
                addr_lo = addr[7:0];
            end
            if (ADDR_W > 16) begin : g_top
                assign unused_top = ^addr[ADDR_W-1:16];
            end else begin : g_notop
                assign unused_top = 1'b0;
            end
        end else begin : g_small
            logic unused_bits;
            // One-byte address: upper bits ride in the select byte
            always_comb begin
                blk     = addr[10:8];
                addr_hi = 8'h00;
                addr_lo = addr[7:0];
            end
            assign unused_bits = ^addr[ADDR_W-1:11];
        end
    endgenerate

    assign sel_wr = DEV_CODE | {4'b0, blk, 1'b0};
    assign sel_rd = sel_wr | 8'h01;
endmodule

// File: rtl/eeprom_retry_cnt.sv
// Select retry counter: counts refused write-mode selects within one
// transfer and flags when the configured limit has been reached.
module eeprom_retry_cnt #(
    parameter int LIMIT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Count refusals, clear at the start of each transfer
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (inc)      cnt_q <= cnt_q + 1'b1;
    end

    assign exhausted = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/eeprom_seq.sv
// Serial EEPROM transaction sequencer. Drives a byte-level two-wire
// engine one command at a time. Assumes the engine answers every
// command with a single eng_done pulse at least one cycle later.
module eeprom_seq
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 8,
    parameter bit WIDE_ADDR = 1'b0,
    parameter int RETRY_MAX = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              wdata_req,
    input  logic [7:0]        wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd,
    output logic [7:0]        eng_wdata,
    output logic              eng_mack,
    input  logic              eng_done,
    input  logic [1:0]        eng_status,
    input  logic [7:0]        eng_rdata
);
    state_e            state_q;
    logic              wait_q;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic              hi_next_q;
    err_e              err_q;
    logic              rd_valid_q;
    logic [7:0]        rd_data_q;

    logic [7:0] sel_wr, sel_rd, addr_hi, addr_lo;
    logic       ev, r_ack, r_nack, is_rd, retry_inc, retry_clr, exhausted;
    bus_cmd_e   cmd_c;

    eeprom_addr_fmt #(.ADDR_W(ADDR_W), .WIDE(WIDE_ADDR)) u_fmt (
        .addr(addr_q), .sel_wr(sel_wr), .sel_rd(sel_rd),
        .addr_hi(addr_hi), .addr_lo(addr_lo)
    );

    eeprom_retry_cnt #(.LIMIT(RETRY_MAX)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(retry_clr), .inc(retry_inc),
        .exhausted(exhausted)
    );

    assign ev        = wait_q && eng_done;
    assign r_ack     = (eng_status == BS_ACK);
    assign r_nack    = (eng_status == BS_NACK);
    assign is_rd     = (op_q != OP_WRITE) && (op_q != OP_ERASE);
    assign retry_clr = (state_q == ST_IDLE);
    assign retry_inc = (state_q == ST_SELW) && ev && r_nack && !exhausted;

    // Present the engine command for the current state when none is pending
    always_comb begin
        eng_cmd_valid = 1'b0;
        cmd_c         = BC_START;
        eng_wdata     = 8'h00;
        eng_mack      = 1'b0;
        wdata_req     = 1'b0;
        if (!wait_q) begin
            unique case (state_q)
                ST_START, ST_RSTART: eng_cmd_valid = 1'b1;
                ST_SELW: begin
                    eng_cmd_valid = 1'b1; cmd_c = BC_SEND; eng_wdata = sel_wr;
                end
                ST_ADDR: begin
                    eng_cmd_valid = 1'b1; cmd_c = BC_SEND;
                    eng_wdata     = hi_next_q ? addr_hi : addr_lo;
                end
                ST_WDATA: begin
                    eng_cmd_valid = 1'b1; cmd_c = BC_SEND;
                    eng_wdata     = (op_q == OP_ERASE) ? ERASE_FILL : wdata;
                    wdata_req     = (op_q == OP_WRITE);
                end
                ST_SELR: begin
                    eng_cmd_valid = 1'b1; cmd_c = BC_SEND; eng_wdata = sel_rd;
                end
                ST_RDATA: begin
                    eng_cmd_valid = 1'b1; cmd_c = BC_RECV;
                    eng_mack      = (left_q != '0);
                end
                ST_STOP: begin
                    eng_cmd_valid = 1'b1; cmd_c = BC_STOP;
                end
                default: ;
            endcase
        end
    end
    assign eng_cmd = cmd_c;

    // Step the transfer on each engine response and track the pending command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            wait_q     <= 1'b0;
            op_q       <= OP_READ;
            addr_q     <= '0;
            left_q     <= '0;
            hi_next_q  <= 1'b0;
            err_q      <= EC_NONE;
            rd_valid_q <= 1'b0;
            rd_data_q  <= 8'h00;
        end else begin
            rd_valid_q <= 1'b0;
            if (eng_done)           wait_q <= 1'b0;
            else if (eng_cmd_valid) wait_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q    <= op_e'(req_op);
                    addr_q  <= req_addr;
                    left_q  <= req_len;
                    err_q   <= EC_NONE;
                    state_q <= ST_START;
                end
                ST_START: if (ev) begin
                    if (r_ack) state_q <= ST_SELW;
                    else begin err_q <= EC_BUS; state_q <= ST_STOP; end
                end
                ST_SELW: if (ev) begin
                    if (r_ack) begin
                        hi_next_q <= WIDE_ADDR;
                        state_q   <= ST_ADDR;
                    end else if (r_nack && !exhausted) state_q <= ST_START;
                    else begin
                        err_q   <= r_nack ? EC_TIMEOUT : EC_BUS;
                        state_q <= ST_STOP;
                    end
                end
                ST_ADDR: if (ev) begin
                    if (!r_ack) begin
                        err_q <= r_nack ? EC_NACK : EC_BUS; state_q <= ST_STOP;
                    end else if (hi_next_q) hi_next_q <= 1'b0;
                    else state_q <= is_rd ? ST_RSTART : ST_WDATA;
                end
                ST_WDATA: if (ev) begin
                    if (!r_ack) begin
                        err_q <= r_nack ? EC_NACK : EC_BUS; state_q <= ST_STOP;
                    end else if (left_q == '0) state_q <= ST_STOP;
                    else left_q <= left_q - 1'b1;
                end
                ST_RSTART: if (ev) begin
                    if (r_ack) state_q <= ST_SELR;
                    else begin err_q <= EC_BUS; state_q <= ST_STOP; end
                end
                ST_SELR: if (ev) begin
                    if (r_ack) state_q <= ST_RDATA;
                    else begin
                        err_q <= r_nack ? EC_NACK : EC_BUS; state_q <= ST_STOP;
                    end
                end
                ST_RDATA: if (ev) begin
                    if (!r_ack) begin err_q <= EC_BUS; state_q <= ST_STOP; end
                    else begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= eng_rdata;
                        if (left_q == '0) state_q <= ST_STOP;
                        else left_q <= left_q - 1'b1;
                    end
                end
                ST_STOP: if (ev) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign err_code  = err_q;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
endmodule

// File: rtl/eeprom_seq_chk.sv
// Protocol checker for eeprom_seq, attached through bind. Sees only ports.
module eeprom_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic [1:0] err_code,
    input logic       rd_valid,
    input logic       wdata_req,
    input logic       eng_cmd_valid,
    input logic [1:0] eng_cmd,
    input logic       eng_done
);
    // R13: a command strobe is never followed directly by another
    assert_single_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |=> !eng_cmd_valid);

    // R12: done lasts one cycle and comes right after the final response
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(eng_done));

    // R12: error cleared on acceptance, held while idle
    assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (err_code == 2'd0));
    assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(err_code));

    // R4: a write byte is consumed only alongside a send command
    assert_pull_with_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_req |-> (eng_cmd_valid && eng_cmd == 2'd1));

    // R8: read data never coincides with the end pulse
    assert_rd_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !done);
endmodule

bind eeprom_seq eeprom_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .err_code(err_code), .rd_valid(rd_valid),
    .wdata_req(wdata_req), .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
    .eng_done(eng_done)
);

// File: tb/tb_eeprom_seq.sv
`timescale 1ns/1ps

// Engine plus device model: answers each command two edges later.
module tb_eeprom_model #(parameter bit WIDE = 1'b0) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd,
    input  logic [7:0]  wbyte,
    input  logic        mack,
    output logic        done,
    output logic [1:0]  status,
    output logic [7:0]  rdata,
    input  int          busy_polls,
    input  int          fault,
    output int          starts,
    output int          stops,
    output int          rd_acks,
    output int          rd_nacks,
    output int          proto,
    output logic [7:0]  last_wsel,
    output logic [7:0]  last_rsel,
    output logic [15:0] last_ptr
);
    logic [7:0]  mem [2048];
    logic        pend;
    logic [1:0]  st_n;
    logic [7:0]  rd_n;
    int          busy_left;
    bit          wrote, sel_exp, hi_got;
    int          mode;       // 0 none, 1 address, 2 write data, 3 read
    logic [7:0]  hi;
    logic [2:0]  blk;
    logic [15:0] ptr;

    initial for (int i = 0; i < 2048; i++) mem[i] = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 0; done <= 0; status <= 0; rdata <= 0;
            starts <= 0; stops <= 0; rd_acks <= 0; rd_nacks <= 0; proto <= 0;
            busy_left <= 0; wrote <= 0; sel_exp <= 0; mode <= 0; hi_got <= 0;
            last_wsel <= 0; last_rsel <= 0; last_ptr <= 0; ptr <= 0; blk <= 0; hi <= 0;
        end else begin
            done <= pend; status <= st_n; rdata <= rd_n; pend <= 0;
            if (cmd_valid) begin
                if (pend || done) proto <= proto + 1;
                pend <= 1; st_n <= 2'd0; rd_n <= 8'h00;
                case (cmd)
                    2'd0: begin
                        starts <= starts + 1; sel_exp <= 1; mode <= 0;
                        if (fault == 2) st_n <= 2'd2;
                    end
                    2'd1: begin
                        if (sel_exp) begin
                            sel_exp <= 0;
                            if (wbyte[7:4] != 4'hA) proto <= proto + 1;
                            if (!wbyte[0]) begin
                                last_wsel <= wbyte;
                                if (fault == 3) st_n <= 2'd2;
                                else if (busy_left > 0) begin
                                    st_n <= 2'd1; busy_left <= busy_left - 1;
                                end else begin
                                    mode <= 1; hi_got <= 0; blk <= wbyte[3:1];
                                end
                            end else begin
                                last_rsel <= wbyte;
                                if (fault == 4) st_n <= 2'd1;
                                else mode <= 3;
                            end
                        end else if (mode == 1) begin
                            if (WIDE && !hi_got) begin
                                hi <= wbyte; hi_got <= 1;
                            end else begin
                                ptr      <= WIDE ? {hi, wbyte} : {5'd0, blk, wbyte};
                                last_ptr <= WIDE ? {hi, wbyte} : {5'd0, blk, wbyte};
                                mode     <= 2;
                            end
                        end else if (mode == 2) begin
                            if (fault == 1) st_n <= 2'd1;
                            else begin
                                mem[ptr[10:0]] <= wbyte; ptr <= ptr + 1; wrote <= 1;
                            end
                        end else proto <= proto + 1;
                    end
                    2'd2: begin
                        if (mode != 3) proto <= proto + 1;
                        rd_n <= mem[ptr[10:0]]; ptr <= ptr + 1;
                        if (mack) rd_acks <= rd_acks + 1;
                        else      rd_nacks <= rd_nacks + 1;
                    end
                    default: begin
                        stops <= stops + 1; mode <= 0; sel_exp <= 0;
                        if (wrote) busy_left <= busy_polls;
                        wrote <= 0;
                    end
                endcase
            end
        end
    end
endmodule

module tb_eeprom_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // ---------------- small-part instance ----------------
    logic        req_valid = 0, req_ready, wdata_req, rd_valid, done;
    logic [1:0]  req_op = 0, err_code;
    logic [15:0] req_addr = 0;
    logic [7:0]  req_len = 0, wdata, rd_data;
    logic        c_v, c_mack, e_done;
    logic [1:0]  c_cmd, e_st;
    logic [7:0]  c_wd, e_rd;
    int          busy_polls = 0, fault = 0;
    int          m_starts, m_stops, m_acks, m_nacks, m_proto;
    logic [7:0]  m_wsel, m_rsel;
    logic [15:0] m_ptr;

    logic [7:0]  wbuf [8];
    int          wreq_total = 0, wbase = 0;
    always @(posedge clk) if (wdata_req) wreq_total <= wreq_total + 1;
    assign wdata = wbuf[(wreq_total - wbase) & 7];

    eeprom_seq #(.WIDE_ADDR(1'b0), .RETRY_MAX(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wdata_req(wdata_req), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .err_code(err_code), .eng_cmd_valid(c_v), .eng_cmd(c_cmd),
        .eng_wdata(c_wd), .eng_mack(c_mack), .eng_done(e_done),
        .eng_status(e_st), .eng_rdata(e_rd));

    tb_eeprom_model #(.WIDE(1'b0)) mdl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(c_v), .cmd(c_cmd), .wbyte(c_wd),
        .mack(c_mack), .done(e_done), .status(e_st), .rdata(e_rd),
        .busy_polls(busy_polls), .fault(fault), .starts(m_starts), .stops(m_stops),
        .rd_acks(m_acks), .rd_nacks(m_nacks), .proto(m_proto),
        .last_wsel(m_wsel), .last_rsel(m_rsel), .last_ptr(m_ptr));

    // ---------------- large-part instance ----------------
    logic        w_req_valid = 0, w_req_ready, w_wdata_req, w_rd_valid, w_done;
    logic [1:0]  w_req_op = 0, w_err;
    logic [15:0] w_req_addr = 0;
    logic [7:0]  w_req_len = 0, w_wdata, w_rd_data;
    logic        wc_v, wc_mack, we_done;
    logic [1:0]  wc_cmd, we_st;
    logic [7:0]  wc_wd, we_rd;
    int          wm_starts, wm_stops, wm_acks, wm_nacks, wm_proto;
    logic [7:0]  wm_wsel, wm_rsel;
    logic [15:0] wm_ptr;
    int          w_pulls = 0;
    logic [7:0]  w_got [$];
    always @(posedge clk) if (w_wdata_req) w_pulls <= w_pulls + 1;
    assign w_wdata = (w_pulls == 0) ? 8'hA5 : 8'h5A;
    always @(negedge clk) if (rst_n && w_rd_valid) w_got.push_back(w_rd_data);

    eeprom_seq #(.WIDE_ADDR(1'b1), .RETRY_MAX(4)) dut_w (
        .clk(clk), .rst_n(rst_n), .req_valid(w_req_valid), .req_ready(w_req_ready),
        .req_op(w_req_op), .req_addr(w_req_addr), .req_len(w_req_len),
        .wdata_req(w_wdata_req), .wdata(w_wdata), .rd_valid(w_rd_valid),
        .rd_data(w_rd_data), .done(w_done), .err_code(w_err),
        .eng_cmd_valid(wc_v), .eng_cmd(wc_cmd), .eng_wdata(wc_wd),
        .eng_mack(wc_mack), .eng_done(we_done), .eng_status(we_st), .eng_rdata(we_rd));

    tb_eeprom_model #(.WIDE(1'b1)) mdl_w (
        .clk(clk), .rst_n(rst_n), .cmd_valid(wc_v), .cmd(wc_cmd), .wbyte(wc_wd),
        .mack(wc_mack), .done(we_done), .status(we_st), .rdata(we_rd),
        .busy_polls(0), .fault(0), .starts(wm_starts), .stops(wm_stops),
        .rd_acks(wm_acks), .rd_nacks(wm_nacks), .proto(wm_proto),
        .last_wsel(wm_wsel), .last_rsel(wm_rsel), .last_ptr(wm_ptr));

    // ---------------- scoreboard ----------------
    logic [7:0] shadow [2048];
    logic [7:0] exp_rd [$];
    int         exp_err [$];
    string      exp_tag [$];

    function automatic void chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    // Monitor: compare read bytes and completion codes as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_rd.size() == 0) chk(0, "R8 unexpected read byte", rd_data, -1);
                else begin
                    automatic logic [7:0] e = exp_rd.pop_front();
                    chk(rd_data == e, "R8 read byte", rd_data, e);
                end
            end
            if (done) begin
                if (exp_err.size() == 0) chk(0, "R12 unexpected done", 1, 0);
                else begin
                    automatic int    e = exp_err.pop_front();
                    automatic string t = exp_tag.pop_front();
                    chk(err_code == e, t, err_code, e);
                end
            end
        end
    end

    // Driver: push expectations, run one request, check its end behaviour
    task automatic run(input int op, input int addr, input int n, input int eerr, input string tag);
        int st0, sp0, a0, n0;
        exp_err.push_back(eerr);
        exp_tag.push_back(tag);
        if (op == 0 && eerr == 0)
            for (int i = 0; i < n; i++) exp_rd.push_back(shadow[(addr + i) & 2047]);
        @(negedge clk);
        wbase = wreq_total;
        st0 = m_starts; sp0 = m_stops; a0 = m_acks; n0 = m_nacks;
        req_op = op[1:0]; req_addr = addr[15:0]; req_len = 8'(n - 1);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(err_code == 0, "R12 error cleared on accept", err_code, 0);
        chk(req_ready == 0, "R12 busy after accept", req_ready, 0);
        do @(negedge clk); while (!done);
        chk(m_stops - sp0 == 1, "R12 one STOP per transfer", m_stops - sp0, 1);
        if (op == 1 && eerr == 0) chk(wreq_total - wbase == n, "R4 one pull per byte", wreq_total - wbase, n);
        if (op == 2) chk(wreq_total - wbase == 0, "R11 erase pulls nothing", wreq_total - wbase, 0);
        if (op == 0 && eerr == 0) begin
            chk(m_acks - a0 == n - 1, "R9 ACK on all but last", m_acks - a0, n - 1);
            chk(m_nacks - n0 == 1, "R9 NACK on last byte", m_nacks - n0, 1);
        end
        if (eerr == 0 && op == 1) for (int i = 0; i < n; i++) shadow[(addr + i) & 2047] = wbuf[i];
        if (eerr == 0 && op == 2) for (int i = 0; i < n; i++) shadow[(addr + i) & 2047] = 8'hFF;
        last_starts = m_starts - st0;
        repeat (3) @(negedge clk);
        chk(err_code == eerr, "R12 error held while idle", err_code, eerr);
        chk(req_ready == 1, "R12 ready after done", req_ready, 1);
    endtask
    int last_starts = 0;

    initial begin
        for (int i = 0; i < 2048; i++) shadow[i] = 8'h00;
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R12 reset ready", req_ready, 1);
        chk(done == 0, "R12 reset done", done, 0);
        chk(err_code == 0, "R12 reset error", err_code, 0);
        chk(c_v == 0, "R13 reset no command", c_v, 0);

        // Small part: select and one-byte address (R1, R2, R4)
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        run(1, 'h5A3, 4, 0, "R4 write ok");
        chk(m_wsel == 8'hAA, "R1 write select", m_wsel, 8'hAA);
        chk(m_ptr == 16'h05A3, "R2 one-byte address", m_ptr, 16'h05A3);
        run(0, 'h5A3, 4, 0, "R8 read ok");
        chk(m_rsel == 8'hAB, "R1 read select", m_rsel, 8'hAB);
        chk(last_starts == 2, "R8 repeated START", last_starts, 2);
        run(0, 'h5A4, 1, 0, "R9 single byte read");

        // Busy polling (R5)
        busy_polls = 3;
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        run(1, 'h010, 2, 0, "R5 write");
        busy_polls = 0;
        run(0, 'h010, 3, 0, "R5 read after busy");
        chk(last_starts == 5, "R5 START per retry", last_starts, 5);

        // Retry limit boundary (R6)
        busy_polls = 4; wbuf[0] = 8'h77;
        run(1, 'h020, 1, 0, "R6 write");
        busy_polls = 5; wbuf[0] = 8'h78;
        run(1, 'h021, 1, 0, "R6 limit tolerated");
        chk(last_starts == 5, "R6 starts at limit", last_starts, 5);
        busy_polls = 0; wbuf[0] = 8'h79;
        run(1, 'h022, 1, 3, "R6 timeout");
        run(0, 'h020, 3, 0, "R6 no data after timeout");

        // Erase (R11)
        run(2, 'h5A4, 3, 0, "R11 erase");
        run(0, 'h5A3, 4, 0, "R11 fill readback");

        // Faults (R10, R7)
        fault = 1; wbuf[0] = 8'h99; wbuf[1] = 8'h9A;
        run(1, 'h100, 2, 1, "R10 data NACK");
        fault = 0;
        run(0, 'h100, 1, 0, "R10 nothing stored");
        fault = 4;
        run(0, 'h5A3, 2, 1, "R10 read select NACK");
        fault = 2;
        run(0, 'h5A3, 2, 2, "R7 START failure");
        fault = 3;
        run(1, 'h200, 1, 2, "R7 select fault");
        fault = 0;
        run(0, 'h010, 2, 0, "R12 recovery");
        chk(exp_rd.size() == 0, "R8 all bytes delivered", exp_rd.size(), 0);
        chk(m_proto == 0, "R13 command ordering", m_proto, 0);

        // Large part (R3)
        @(negedge clk);
        w_req_op = 2'd1; w_req_addr = 16'h1234; w_req_len = 8'd1; w_req_valid = 1;
        @(negedge clk); w_req_valid = 0;
        do @(negedge clk); while (!w_done);
        chk(w_err == 0, "R3 wide write status", w_err, 0);
        chk(wm_wsel == 8'hA0, "R3 wide write select", wm_wsel, 8'hA0);
        chk(wm_ptr == 16'h1234, "R3 high byte first", wm_ptr, 16'h1234);
        repeat (2) @(negedge clk);
        w_req_op = 2'd0; w_req_valid = 1;
        @(negedge clk); w_req_valid = 0;
        do @(negedge clk); while (!w_done);
        chk(w_err == 0, "R3 wide read status", w_err, 0);
        chk(wm_rsel == 8'hA1, "R3 wide read select", wm_rsel, 8'hA1);
        chk(w_got.size() == 2, "R3 wide byte count", w_got.size(), 2);
        if (w_got.size() == 2) begin
            chk(w_got[0] == 8'hA5, "R3 wide byte 0", w_got[0], 8'hA5);
            chk(w_got[1] == 8'h5A, "R3 wide byte 1", w_got[1], 8'h5A);
        end
        chk(wm_proto == 0, "R13 wide command ordering", wm_proto, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R12 watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule